// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block is a multicycle arithmetic unit for a processor's integer pipeline. It computes either a full-width product or a quotient and remainder of two operands. It uses a single shift-and-add/subtract datapath with one shared adder, and it retires one result bit per cycle. The caller pulses a start input with the operands and two mode bits. The mode bits select multiply or divide, and signed or unsigned treatment. The caller then waits for the one-cycle completion pulse.

The result lands in two result registers, a high half and a low half, that can be read on their own.
- For a multiply, the high half holds the upper word of the double-width product and the low half holds the lower word.
- For a divide, the high half holds the remainder and the low half holds the quotient.

Signed operations run on operand magnitudes, and the signs are corrected in a final cycle. The unit does no divide-by-zero or overflow detection. Software is expected to test for those cases if it needs to.

Top module: `mulDivUnit`

## Requirements
- R1: With `opDiv`=0 and `opSigned`=0, the operands are treated as unsigned. `hiOut` shows bits [2W-1:W] of the 2W-bit product and `loOut` shows bits [W-1:0].
- R2: With `opDiv`=0 and `opSigned`=1, the operands are two's complement. `hiOut`:`loOut` form the two's complement 2W-bit product.
- R3: With `opDiv`=1 and `opSigned`=0, `loOut` holds the unsigned quotient and `hiOut` holds the unsigned remainder.
- R4: With `opDiv`=1 and `opSigned`=1, the quotient is truncated toward zero. It is negative when the operand signs differ, and the remainder carries the sign of the dividend.
- R5: An accepted start (`startReq` high while `busy` is low) raises `busy` in the next cycle. `busy` stays high for exactly W+2 cycles: one setup cycle, W iteration cycles and one fix-up cycle. `done` is high for exactly one cycle, the first cycle after `busy` falls, and `hiOut`/`loOut` hold the new result from that cycle onward.
- R6: A `startReq` pulse while `busy` is high is ignored. The running operation keeps its operands and its cycle count.
- R7: An unsigned divide by zero completes in the normal W+2 busy cycles. It gives a quotient of all ones and a remainder equal to the dividend.
- R8: `hiOut` and `loOut` do not change while `busy` is high. They keep the last result until the next completion.
- R9: After reset, `busy` and `done` are 0 and `hiOut`/`loOut` are 0.
- R10: A signed divide of the most negative value by -1 gives a quotient equal to the most negative value and a remainder of 0. This is a wrap, and it is not flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse, sampled when idle |
| opDiv | input | 1 | 1 = divide, 0 = multiply |
| opSigned | input | 1 | 1 = two's complement operands |
| srcA | input | WIDTH | Multiplicand or dividend |
| srcB | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hiOut | output | WIDTH | High result register (upper product or remainder) |
| loOut | output | WIDTH | Low result register (lower product or quotient) |

## Verification
The bench builds the unit at its default width of 32. At that width the extreme operands are reachable directly: the most negative value, all ones, and the signed divide that overflows. Those operands push the shared adder's carry and borrow bit and the magnitude conversion to their limits. Expected results come from 64-bit integer arithmetic in the bench. Each operation's busy window is counted cycle by cycle, and the bench also injects a start pulse in the middle of an operation.

// File: rtl/mulDivPkg.sv
package mulDivPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } mdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOps;
    logic setup;
    logic iterate;
    logic finish;
  } mdCtl_t;
endpackage

// File: rtl/mulDivAdder.sv
module mulDivAdder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH:0] addX,
  input  logic [WIDTH:0] addY,
  input  logic           doSub,
  output logic [WIDTH:0] sum
);
  logic [WIDTH:0] yEff;
  always_comb begin
    yEff = doSub ? ~addY : addY;
    sum  = addX + yEff + {{WIDTH{1'b0}}, doSub};
  end
endmodule

// File: rtl/mulDivCtrl.sv
module mulDivCtrl
  import mulDivPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  output mdCtl_t ctl,
  output logic   busy,
  output logic   done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  mdState_e state;
  logic [CW-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == ST_FIX);
      case (state)
        ST_IDLE:  if (startReq) state <= ST_SETUP;
        ST_SETUP: begin
          state   <= ST_ITER;
          stepCnt <= '0;
        end
        ST_ITER: begin
          if (stepCnt == LAST_STEP) state <= ST_FIX;
          else stepCnt <= stepCnt + 1'b1;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadOps = (state == ST_IDLE) && startReq;
    ctl.setup   = (state == ST_SETUP);
    ctl.iterate = (state == ST_ITER);
    ctl.finish  = (state == ST_FIX);
    busy        = (state != ST_IDLE);
  end
endmodule

// File: rtl/mulDivPath.sv
module mulDivPath
  import mulDivPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdCtl_t           ctl,
  input  logic             opDiv,
  input  logic             opSigned,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);
  localparam int W2 = 2 * WIDTH;

  logic [WIDTH-1:0] rawA, rawB, magB;
  logic             isDiv, isSigned, negMain, negRem;
  logic [W2:0]      work;
  logic [W2:0]      shifted;
  logic [WIDTH:0]   addX, addY, sum;
  logic [W2:0]      nextWork;
  logic [WIDTH-1:0] absA, absB;
  logic [W2-1:0]    prodFix;
  logic [WIDTH-1:0] quotFix, remFix;

  function automatic logic [WIDTH-1:0] magOf(input logic [WIDTH-1:0] v, input logic sgn);
    return (sgn && v[WIDTH-1]) ? (~v + 1'b1) : v;
  endfunction

  mulDivAdder #(.WIDTH(WIDTH)) uAdder (
    .addX (addX),
    .addY (addY),
    .doSub(isDiv),
    .sum  (sum)
  );

  always_comb begin
    absA    = magOf(rawA, isSigned);
    absB    = magOf(rawB, isSigned);
    shifted = {work[W2-1:0], 1'b0};
    if (isDiv) begin
      // restoring step: trial subtract from shifted partial remainder
      addX = shifted[W2:WIDTH];
      addY = {1'b0, magB};
      nextWork = sum[WIDTH] ? shifted : {sum, shifted[WIDTH-1:1], 1'b1};
    end else begin
      // add partial product when multiplier LSB set, then shift right
      addX = {1'b0, work[W2-1:WIDTH]};
      addY = work[0] ? {1'b0, magB} : '0;
      nextWork = {1'b0, sum, work[WIDTH-1:1]};
    end
    prodFix = negMain ? (~work[W2-1:0] + 1'b1) : work[W2-1:0];
    quotFix = negMain ? (~work[WIDTH-1:0] + 1'b1) : work[WIDTH-1:0];
    remFix  = negRem ? (~work[W2-1:WIDTH] + 1'b1) : work[W2-1:WIDTH];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawA <= '0; rawB <= '0; magB <= '0;
      isDiv <= 1'b0; isSigned <= 1'b0;
      negMain <= 1'b0; negRem <= 1'b0;
      work <= '0; hiOut <= '0; loOut <= '0;
    end else begin
      if (ctl.loadOps) begin
        rawA     <= srcA;
        rawB     <= srcB;
        isDiv    <= opDiv;
        isSigned <= opSigned;
      end
      if (ctl.setup) begin
        magB    <= absB;
        negMain <= isSigned && (rawA[WIDTH-1] ^ rawB[WIDTH-1]);
        negRem  <= isSigned && rawA[WIDTH-1];
        work    <= {{(WIDTH+1){1'b0}}, absA};
      end
      if (ctl.iterate) work <= nextWork;
      if (ctl.finish) begin
        if (isDiv) begin
          hiOut <= remFix;
          loOut <= quotFix;
        end else begin
          hiOut <= prodFix[W2-1:WIDTH];
          loOut <= prodFix[WIDTH-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/mulDivUnit.sv
module mulDivUnit
  import mulDivPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             opDiv,
  input  logic             opSigned,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);
  mdCtl_t ctl;

  mulDivCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done)
  );

  mulDivPath #(.WIDTH(WIDTH)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opDiv   (opDiv),
    .opSigned(opSigned),
    .srcA    (srcA),
    .srcB    (srcB),
    .hiOut   (hiOut),
    .loOut   (loOut)
  );
endmodule

// File: rtl/mulDivUnitChk.sv
module mulDivUnitChk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hiOut,
  input logic [WIDTH-1:0] loOut
);
  localparam int BUSY_LEN = WIDTH + 2;
  localparam int BCW = $clog2(BUSY_LEN + 2);

  logic [BCW-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyCnt == BCW'(BUSY_LEN));

  assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyCnt < BCW'(BUSY_LEN));

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_needed_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  assert_hold_hi_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(hiOut));

  assert_hold_lo_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(loOut));
endmodule

bind mulDivUnit mulDivUnitChk #(.WIDTH(WIDTH)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .startReq(startReq),
  .busy    (busy),
  .done    (done),
  .hiOut   (hiOut),
  .loOut   (loOut)
);

// File: tb/mulDivUnit_test.sv
module mulDivUnit_test;
  localparam int W = 32;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic opDiv = 1'b0;
  logic opSigned = 1'b0;
  logic [W-1:0] srcA = '0;
  logic [W-1:0] srcB = '0;
  logic busy, done;
  logic [W-1:0] hiOut, loOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mulDivUnit #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opDiv(opDiv),
    .opSigned(opSigned), .srcA(srcA), .srcB(srcB),
    .busy(busy), .done(done), .hiOut(hiOut), .loOut(loOut)
  );

  // stimulus table: {div, signed, A, B}
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'd8,          32'd9},
    {1'b0, 1'b0, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {1'b0, 1'b0, 32'h1234_5678,  32'h9ABC_DEF0},
    {1'b0, 1'b1, 32'hFFFF_FFFD,  32'd7},
    {1'b0, 1'b1, 32'h8000_0000,  32'h8000_0000},
    {1'b0, 1'b1, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {1'b1, 1'b0, 32'd74,         32'd8},
    {1'b1, 1'b0, 32'hFFFF_FFFF,  32'd10},
    {1'b1, 1'b0, 32'd5,          32'd9},
    {1'b1, 1'b1, 32'hFFFF_FFF9,  32'd2},
    {1'b1, 1'b1, 32'd7,          32'hFFFF_FFFE},
    {1'b1, 1'b1, 32'hFFFF_FFF9,  32'hFFFF_FFFE}
  };

  function automatic logic [63:0] refResult(input logic dv, input logic sg,
                                            input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [63:0] sa, sb, q, r;
    logic [63:0] ua, ub;
    if (!dv) begin
      if (sg) begin
        sa = 64'(signed'(a)); sb = 64'(signed'(b));
        return 64'(sa * sb);
      end
      ua = {32'd0, a}; ub = {32'd0, b};
      return ua * ub;
    end
    if (sg) begin
      sa = 64'(signed'(a)); sb = 64'(signed'(b));
      q = sa / sb; r = sa % sb;
      return {r[31:0], q[31:0]};
    end
    return {a % b, a / b};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // runs one operation; returns the number of busy cycles and the done flag
  task automatic runOp(input logic dv, input logic sg, input logic [W-1:0] a,
                       input logic [W-1:0] b, input int injectAt,
                       output int busyLen, output logic doneSeen);
    @(negedge clk);
    opDiv = dv; opSigned = sg; srcA = a; srcB = b; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    busyLen = 0;
    while (busy && busyLen < 200) begin
      busyLen++;
      if (busyLen == injectAt) begin
        opDiv = ~dv; opSigned = ~sg; srcA = 32'd3; srcB = 32'd1; startReq = 1'b1;
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
    end
    startReq = 1'b0;
    doneSeen = done;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bl;
    logic dn;
    logic [63:0] hold;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {31'd0, busy, 31'd0, done}, 64'd0);
    check("R9", {hiOut, loOut}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      runOp(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0], 0, bl, dn);
      if (!VEC[i][65] && !VEC[i][64]) check("R1", {hiOut, loOut}, refResult(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]));
      else if (!VEC[i][65])           check("R2", {hiOut, loOut}, refResult(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]));
      else if (!VEC[i][64])           check("R3", {hiOut, loOut}, refResult(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]));
      else                            check("R4", {hiOut, loOut}, refResult(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]));
      check("R5", 64'(bl), 64'(W + 2));
      check("R5", {63'd0, dn}, 64'd1);
      @(negedge clk);
      check("R5", {63'd0, done}, 64'd0);
    end

    // R4 explicit: -7 / 2 -> q=-3, r=-1
    runOp(1'b1, 1'b1, 32'hFFFF_FFF9, 32'd2, 0, bl, dn);
    check("R4", {hiOut, loOut}, {32'hFFFF_FFFF, 32'hFFFF_FFFD});

    // R7: unsigned divide by zero
    runOp(1'b1, 1'b0, 32'hDEAD_BEEF, 32'd0, 0, bl, dn);
    check("R7", {hiOut, loOut}, {32'hDEAD_BEEF, 32'hFFFF_FFFF});
    check("R7", 64'(bl), 64'(W + 2));

    // R10: most negative / -1
    runOp(1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 0, bl, dn);
    check("R10", {hiOut, loOut}, {32'd0, 32'h8000_0000});

    // R6: start during busy is ignored
    runOp(1'b0, 1'b0, 32'd1000, 32'd1000, 5, bl, dn);
    check("R6", {hiOut, loOut}, 64'd1_000_000);
    check("R6", 64'(bl), 64'(W + 2));
    repeat (3) @(negedge clk);
    check("R6", {63'd0, busy}, 64'd0);

    // R8: result held while idle and through next operation's busy window
    hold = {hiOut, loOut};
    repeat (4) @(negedge clk);
    check("R8", {hiOut, loOut}, hold);
    @(negedge clk);
    opDiv = 1'b1; opSigned = 1'b0; srcA = 32'd100; srcB = 32'd7; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (20) @(negedge clk);
    check("R8", {hiOut, loOut}, hold);
    while (busy) @(negedge clk);
    check("R3", {hiOut, loOut}, {32'd2, 32'd14});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule